// File: doc/BRIEF.md
# Memory Write-Path Command Controller

This block sits in the memory clock domain. It empties a show-ahead FIFO of wide sample words into the write side of a memory controller's command interface, which uses a flat address space. Each FIFO word is twice the width of one controller data beat. The block therefore splits every word into two beats and sends them in order. Each beat goes out as one write command, with its address and its data presented in the same cycle.

The controller may stall at any time because of refresh, precharge or full internal buffers. It signals this by dropping its command-ready or write-data-ready line. While the controller stalls, the block keeps its request steady: the command, the address and the data stay unchanged. The FIFO is not popped until both halves of the current word have been taken, so no sample is lost or repeated.

The write address is kept inside the block. It can be loaded from an outside start value and advances by one burst after each accepted beat. A sticky flag records any attempt to write into the FIFO while it is full.

Top module: `wp_cmd_ctrl`

## Requirements
- R1: `cmd_en` is high in exactly the cycles where `fifo_empty` is low, and `cmd_code` carries the write code 3'b000 whenever `cmd_en` is high.
- R2: `wdata_en` is high in exactly the same cycles as `cmd_en`, so the command and its data are always issued together.
- R3: A beat is taken only in a cycle where `cmd_en`, `cmd_rdy` and `wdata_rdy` are all high. In any other cycle with a pending beat, `cmd_addr` and `wdata` stay unchanged into the next cycle, unless an address load intervenes.
- R4: For each FIFO word, the first beat presented on `wdata` is bits [DATA_W-1:0] (the low half) and the second beat is bits [2*DATA_W-1:DATA_W] (the high half).
- R5: `fifo_rd_en` is high only in the cycle where the second (high-half) beat of a word is taken. It is therefore never high while the FIFO is empty or while `cmd_rdy` is low.
- R6: After each taken beat, `cmd_addr` increases by BURST (8), wrapping modulo 2^ADDR_W.
- R7: When `addr_load` is high, `cmd_addr` equals `addr_start` in the next cycle. This overrides the increment from a beat taken in the same cycle and leaves the beat phase unchanged.
- R8: `overflow` goes high in the cycle after `fifo_full` and `fifo_wr` are high together. It then stays high until reset.
- R9: After synchronous reset, `cmd_addr` is 0, the beat phase is the low half, and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_dout | input | 2*DATA_W | Show-ahead FIFO head word |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_full | input | 1 | FIFO write side is full |
| fifo_wr | input | 1 | Upstream write strobe into the FIFO |
| fifo_rd_en | output | 1 | Pop the FIFO head word |
| cmd_rdy | input | 1 | Controller accepts a command |
| wdata_rdy | input | 1 | Controller accepts write data |
| addr_load | input | 1 | Load the write address from addr_start |
| addr_start | input | ADDR_W | Address value to load |
| cmd_en | output | 1 | Command request |
| cmd_code | output | 3 | Command code (write = 3'b000) |
| cmd_addr | output | ADDR_W | Command address |
| wdata_en | output | 1 | Write data valid |
| wdata | output | DATA_W | Write data beat |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
Two events can fall in the same cycle: an address load, and the taking of a beat, which would otherwise step the address. The bench raises `addr_load` at random, in about one cycle in sixteen. It also raises both ready lines at random, and adds a directed cycle where both happen on purpose. In every such cycle, the expected address is the loaded value with no increment applied, while the beat phase still advances and the pop still follows the phase. A cycle where a pop and an upstream write meet a full FIFO is also provoked often, because the model FIFO is only four words deep. It is judged against the model's sticky overflow.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int unsigned UI_DATA_W = 512;
    localparam int unsigned UI_ADDR_W = 28;
    localparam int unsigned UI_BURST  = 8;

    typedef enum logic [2:0] {
        UI_CMD_WRITE = 3'b000,
        UI_CMD_READ  = 3'b001
    } ui_cmd_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } beat_phase_e;

    typedef struct packed {
        logic load;
        logic step;
    } addr_op_t;

    function automatic beat_phase_e next_phase(input beat_phase_e p);
        return (p == PH_LOW) ? PH_HIGH : PH_LOW;
    endfunction

endpackage

// File: rtl/wp_beat_sel.sv
module wp_beat_sel
    import wp_pkg::*;
#(
    parameter int unsigned DATA_W = UI_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2*DATA_W-1:0]   word_i,
    input  logic                  take_i,
    output logic [DATA_W-1:0]     beat_o,
    output logic                  last_o
);
    localparam int unsigned HALVES = 2;

    beat_phase_e phase_q;
    logic [DATA_W-1:0] halves [HALVES];

    for (genvar h = 0; h < HALVES; h++) begin : g_split
        assign halves[h] = word_i[h*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LOW;
        end else if (take_i) begin
            phase_q <= next_phase(phase_q);
        end
    end

    always_comb begin
        beat_o = (phase_q == PH_HIGH) ? halves[1] : halves[0];
        last_o = (phase_q == PH_HIGH);
    end

endmodule

// File: rtl/wp_addr_gen.sv
module wp_addr_gen
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W = UI_ADDR_W,
    parameter int unsigned STEP   = UI_BURST
) (
    input  logic              clk,
    input  logic              rst,
    input  addr_op_t          op_i,
    input  logic [ADDR_W-1:0] start_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (op_i.load) begin
            addr_q <= start_i;
        end else if (op_i.step) begin
            addr_q <= addr_q + STEP_V;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/wp_ovf_mon.sv
module wp_ovf_mon (
    input  logic clk,
    input  logic rst,
    input  logic full_i,
    input  logic wr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (full_i && wr_i) begin
            flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/wp_cmd_ctrl.sv
module wp_cmd_ctrl
    import wp_pkg::*;
#(
    parameter int unsigned DATA_W = UI_DATA_W,
    parameter int unsigned ADDR_W = UI_ADDR_W,
    parameter int unsigned BURST  = UI_BURST
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*DATA_W-1:0] fifo_dout,
    input  logic                fifo_empty,
    input  logic                fifo_full,
    input  logic                fifo_wr,
    output logic                fifo_rd_en,
    input  logic                cmd_rdy,
    input  logic                wdata_rdy,
    input  logic                addr_load,
    input  logic [ADDR_W-1:0]   addr_start,
    output logic                cmd_en,
    output logic [2:0]          cmd_code,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic                wdata_en,
    output logic [DATA_W-1:0]   wdata,
    output logic                overflow
);
    logic     pending;
    logic     take;
    logic     last_beat;
    addr_op_t aop;

    always_comb begin
        pending  = !fifo_empty;
        take     = pending && cmd_rdy && wdata_rdy;
        aop.load = addr_load;
        aop.step = take;
    end

    wp_beat_sel #(.DATA_W(DATA_W)) u_beat (
        .clk    (clk),
        .rst    (rst),
        .word_i (fifo_dout),
        .take_i (take),
        .beat_o (wdata),
        .last_o (last_beat)
    );

    wp_addr_gen #(.ADDR_W(ADDR_W), .STEP(BURST)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .op_i    (aop),
        .start_i (addr_start),
        .addr_o  (cmd_addr)
    );

    wp_ovf_mon u_ovf (
        .clk    (clk),
        .rst    (rst),
        .full_i (fifo_full),
        .wr_i   (fifo_wr),
        .flag_o (overflow)
    );

    always_comb begin
        cmd_en     = pending;
        wdata_en   = pending;
        cmd_code   = UI_CMD_WRITE;
        fifo_rd_en = take && last_beat;
    end

endmodule

// File: rtl/wp_cmd_ctrl_chk.sv
module wp_cmd_ctrl_chk #(
    parameter int unsigned ADDR_W = 28,
    parameter int unsigned BURST  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              fifo_empty,
    input logic              fifo_full,
    input logic              fifo_wr,
    input logic              fifo_rd_en,
    input logic              cmd_rdy,
    input logic              wdata_rdy,
    input logic              addr_load,
    input logic [ADDR_W-1:0] addr_start,
    input logic              cmd_en,
    input logic [2:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              wdata_en,
    input logic              overflow
);
    // R1
    wr_code_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_en |-> (cmd_code == 3'b000));

    // R2
    pair_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (wdata_en == cmd_en) && (cmd_en != fifo_empty));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_en && !(cmd_rdy && wdata_rdy) && !addr_load)
        |=> (cmd_en && $stable(cmd_addr)));

    // R5
    pop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |-> (!fifo_empty && cmd_rdy && wdata_rdy));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_en && cmd_rdy && wdata_rdy && !addr_load)
        |=> (cmd_addr == ADDR_W'($past(cmd_addr) + ADDR_W'(BURST))));

    // R7
    addr_load_chk: assert property (@(posedge clk) disable iff (rst)
        addr_load |=> (cmd_addr == $past(addr_start)));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && fifo_wr) |=> overflow);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

endmodule

bind wp_cmd_ctrl wp_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .BURST(BURST)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_wr    (fifo_wr),
    .fifo_rd_en (fifo_rd_en),
    .cmd_rdy    (cmd_rdy),
    .wdata_rdy  (wdata_rdy),
    .addr_load  (addr_load),
    .addr_start (addr_start),
    .cmd_en     (cmd_en),
    .cmd_code   (cmd_code),
    .cmd_addr   (cmd_addr),
    .wdata_en   (wdata_en),
    .overflow   (overflow)
);

// File: tb/sim_wp_cmd_ctrl.sv
module sim_wp_cmd_ctrl;
    localparam int DATA_W = 512;
    localparam int WORD_W = 2 * DATA_W;
    localparam int ADDR_W = 28;
    localparam int BURST  = 8;
    localparam int DEPTH  = 4;
    localparam int CYCLES = 4000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [WORD_W-1:0] fifo_dout = '0;
    logic              fifo_empty = 1'b1;
    logic              fifo_full = 1'b0;
    logic              fifo_wr = 1'b0;
    logic              fifo_rd_en;
    logic              cmd_rdy = 1'b0;
    logic              wdata_rdy = 1'b0;
    logic              addr_load = 1'b0;
    logic [ADDR_W-1:0] addr_start = '0;
    logic              cmd_en;
    logic [2:0]        cmd_code;
    logic [ADDR_W-1:0] cmd_addr;
    logic              wdata_en;
    logic [DATA_W-1:0] wdata;
    logic              overflow;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [WORD_W-1:0] q[$];
    logic [ADDR_W-1:0] m_addr = '0;
    bit                m_high = 1'b0;
    bit                m_ovf = 1'b0;

    always #4 clk = ~clk;

    wp_cmd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST(BURST)) u0 (
        .clk(clk), .rst(rst), .fifo_dout(fifo_dout), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_rd_en(fifo_rd_en),
        .cmd_rdy(cmd_rdy), .wdata_rdy(wdata_rdy), .addr_load(addr_load),
        .addr_start(addr_start), .cmd_en(cmd_en), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .wdata_en(wdata_en), .wdata(wdata), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [WORD_W-1:0] rand_word();
        logic [WORD_W-1:0] w;
        for (int i = 0; i < WORD_W / 32; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] exp_beat(input logic [WORD_W-1:0] w, input bit hi);
        return hi ? w[WORD_W-1:DATA_W] : w[DATA_W-1:0];
    endfunction

    task automatic refresh();
        fifo_empty = (q.size() == 0);
        fifo_full  = (q.size() >= DEPTH);
        fifo_dout  = (q.size() != 0) ? q[0] : '0;
    endtask

    // one cycle: inputs set at negedge, outputs checked, model advanced after posedge
    task automatic step(input bit cr, input bit wr, input bit push, input bit ld,
                        input logic [ADDR_W-1:0] st);
        bit en;
        bit take;
        bit pop;
        bit was_full;
        @(negedge clk);
        cmd_rdy = cr; wdata_rdy = wr; fifo_wr = push; addr_load = ld; addr_start = st;
        #1;
        en = (q.size() != 0);
        take = en && cr && wr;
        pop = take && m_high;
        was_full = (q.size() >= DEPTH);
        chk(cmd_en == en, "R1 cmd_en", DATA_W'(cmd_en), DATA_W'(en));
        if (en) chk(cmd_code == 3'b000, "R1 cmd_code", DATA_W'(cmd_code), '0);
        chk(wdata_en == en, "R2 wdata_en", DATA_W'(wdata_en), DATA_W'(en));
        chk(cmd_addr == m_addr, "R3/R6/R7 cmd_addr", DATA_W'(cmd_addr), DATA_W'(m_addr));
        if (en) chk(wdata == exp_beat(q[0], m_high), "R3/R4 wdata", wdata, exp_beat(q[0], m_high));
        chk(fifo_rd_en == pop, "R5 fifo_rd_en", DATA_W'(fifo_rd_en), DATA_W'(pop));
        chk(overflow == m_ovf, "R8 overflow", DATA_W'(overflow), DATA_W'(m_ovf));
        @(posedge clk);
        #1;
        if (pop) void'(q.pop_front());
        if (push && !was_full) q.push_back(rand_word());
        if (push && was_full) m_ovf = 1'b1;
        if (ld) m_addr = st;
        else if (take) m_addr = m_addr + ADDR_W'(BURST);
        if (take) m_high = !m_high;
        refresh();
    endtask

    initial begin
        void'($urandom(32'h0000_5eed));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk(cmd_addr == '0, "R9 addr after reset", DATA_W'(cmd_addr), '0);
        chk(overflow == 1'b0, "R9 overflow after reset", DATA_W'(overflow), '0);
        chk(cmd_en == 1'b0, "R9 idle after reset", DATA_W'(cmd_en), '0);

        // R4 directed: one word, both beats taken back to back
        step(1'b0, 1'b0, 1'b1, 1'b0, '0);
        chk(m_high == 1'b0, "R9 phase starts low", '0, '0);
        step(1'b1, 1'b1, 1'b0, 1'b0, '0);
        step(1'b1, 1'b1, 1'b0, 1'b0, '0);

        // R3 directed: long stall with command-ready high but data-ready low
        step(1'b0, 1'b0, 1'b1, 1'b0, '0);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 1'b0, '0);

        // R7 directed: load in the same cycle as a taken beat, near the wrap point
        step(1'b1, 1'b1, 1'b0, 1'b1, {ADDR_W{1'b1}} - ADDR_W'(BURST - 1));
        step(1'b0, 1'b0, 1'b1, 1'b0, '0);
        // R6 wrap across the top of the address space
        step(1'b1, 1'b1, 1'b0, 1'b0, '0);
        step(1'b1, 1'b1, 1'b0, 1'b0, '0);

        // R8 directed: fill, then write while full
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b0, 1'b1, 1'b0, '0);

        // R1..R8 random mix
        for (int i = 0; i < CYCLES; i++) begin
            bit ld = ($urandom_range(0, 15) == 0);
            logic [ADDR_W-1:0] st = ($urandom_range(0, 3) == 0)
                ? ({ADDR_W{1'b1}} - ADDR_W'(8 * $urandom_range(0, 3)))
                : ADDR_W'($urandom);
            step($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0,
                 $urandom_range(0, 2) == 0, ld, st);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule